// File: doc/BRIEF.md
# Configurable SPI Host Shift Engine

This block is the serial core of an SPI host. A user-side strobe launches one 8-bit full-duplex transfer. The engine drives the clock, the select line and the output data line. It also captures the input data line, most significant bit first. When the frame is over it raises a one-cycle done pulse, and the received byte is then valid.

A seven-bit control register sets the clock idle level and which clock edge moves the output data. It also picks whether input data is captured in the middle or at the end of each bit time, and whether the first clock edge follows select quickly. Three of its bits invert the select, input and output lines independently. An 8-bit divider register sets the half period of the serial clock. Both registers are copied at the start of a transfer, so software may rewrite them while a frame is in flight without disturbing it.

Top module: `spi_host_engine`

## Requirements
- R1: After reset, busy and done are 0, sck is 0, ss is 1 and sdo is 0. The control register resets to 7'h10, which means select is active-low and every other control bit is 0. The divider resets to 0.
- R2: Control bit positions are: bit 0 = clock idles high, bit 1 = output changes on the active-to-idle edge, bit 2 = sample at end of bit time, bit 3 = fast start, bit 4 = select active-low, bit 5 = invert input, bit 6 = invert output. While idle, sck equals bit 0, ss is at its inactive level, and sdo equals bit 6.
- R3: A one-cycle start while idle raises busy and runs exactly 16 sck edges carrying 8 bits MSB first in each direction. At the end, busy falls and done pulses for exactly one cycle, with rxByte holding the received byte.
- R4: With bit 1 = 1, the first output bit is on sdo before the first sck edge and changes on active-to-idle edges. With bit 1 = 0, each output bit is presented on an idle-to-active edge.
- R5: With bit 2 = 0, input is captured at the mid-bit edge, the one opposite the edge that changes output. With bit 2 = 1, input is captured one half period later, at the end of the bit time. For the last bit, when nothing follows it, that point is the end of the tail.
- R6: With fast start off, the first sck edge comes (divider+1) system clocks after select goes active.
- R7: With fast start on, the first sck edge comes exactly one system clock after select goes active.
- R8: Each sck half period lasts (divider+1) system clocks. After the last edge, select stays active for one more half period.
- R9: With bit 5 set, received line values are inverted before storage. With bit 6 set, transmitted bits are inverted on sdo.
- R10: Writes to the control or divider register while busy do not affect the running transfer. They take effect from the next idle period and transfer.
- R11: ss holds its active level for the whole transfer, from the start cycle to the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control register write enable |
| cfgIn | input | 7 | Control register write data |
| divWe | input | 1 | Divider register write enable |
| divIn | input | 8 | Divider register write data (half period minus one) |
| start | input | 1 | One-cycle transfer start strobe |
| txByte | input | 8 | Byte to transmit, taken at start |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle pulse at end of transfer |
| rxByte | output | 8 | Last received byte |
| sck | output | 1 | Serial clock |
| ss | output | 1 | Select line |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench's peripheral model places an inverted value on sdi during one half of each bit and the true value during the other half, with the choice set by the sample mode. A design that captures at the wrong point therefore returns a corrupted byte instead of passing by luck. The delay from select to the first clock edge and the first half period are timed in system clocks with the divider at 0 and above 0, so an off-by-one counter or a fast start that is ignored shows up as a wrong duration. A control rewrite in mid-frame flips the edge, sample, and polarity settings. A design that does not hold its copy of the settings garbles that frame, and one that never adopts the new settings shows the wrong idle sdo level afterwards.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  // Control register, packed so that bit 0 is idleHigh and bit 6 is txInvert.
  typedef struct packed {
    logic txInvert;          // bit 6
    logic rxInvert;          // bit 5
    logic selActLow;         // bit 4
    logic quickStart;        // bit 3
    logic sampleLate;        // bit 2
    logic changeOnTrailing;  // bit 1
    logic idleHigh;          // bit 0
  } cfg_t;

  localparam int   CFG_W     = 7;
  localparam cfg_t CFG_RESET = 7'h10;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // transfer accepted
    logic toggle;  // sck edge this cycle
    logic drive;   // present next output bit
    logic sample;  // capture input bit
    logic finish;  // end of frame
  } strobe_t;

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgIn,
  input  logic             divWe,
  input  logic [DIV_W-1:0] divIn,
  input  logic             load,
  input  logic             busy,
  output cfg_t             cfgAct,
  output logic [DIV_W-1:0] divAct
);

  cfg_t             cfgLive, cfgSnap;
  logic [DIV_W-1:0] divLive, divSnap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLive <= CFG_RESET;
      divLive <= '0;
    end else begin
      if (cfgWe) cfgLive <= cfg_t'(cfgIn);
      if (divWe) divLive <= divIn;
    end
  end

  // Copy taken when a transfer is accepted, held until it ends.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSnap <= CFG_RESET;
      divSnap <= '0;
    end else if (load) begin
      cfgSnap <= cfgLive;
      divSnap <= divLive;
    end
  end

  assign cfgAct = busy ? cfgSnap : cfgLive;
  assign divAct = busy ? divSnap : divLive;

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divAct,
  input  logic             changeOnTrailing,
  input  logic             sampleLate,
  input  logic             quickStart,
  output logic             busy,
  output strobe_t          stb
);

  localparam int TICKS = 2 * DATA_W;
  localparam int IDX_W = $clog2(TICKS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TICKS);
  localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(TICKS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           state;
  logic [DIV_W-1:0] halfCnt;
  logic [IDX_W-1:0] tickIdx;
  logic             tick, lastTick, oddTick, leadChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      tickIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            halfCnt <= quickStart ? '0 : divAct;
            tickIdx <= '0;
          end
        end
        ST_RUN: begin
          if (halfCnt == '0) begin
            halfCnt <= divAct;
            if (tickIdx == LAST_IDX) state <= ST_IDLE;
            else tickIdx <= tickIdx + 1'b1;
          end else begin
            halfCnt <= halfCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Tick k (0..TICKS-1) is sck edge k; tick TICKS closes the tail.
  assign tick       = (state == ST_RUN) && (halfCnt == '0);
  assign lastTick   = (tickIdx == LAST_IDX);
  assign oddTick    = tickIdx[0];
  assign leadChange = !changeOnTrailing;  // output moves on leading edges

  always_comb begin
    stb        = '0;
    stb.load   = (state == ST_IDLE) && start;
    stb.toggle = tick && !lastTick;
    stb.finish = tick && lastTick;
    if (changeOnTrailing) stb.drive = tick && oddTick && (tickIdx < PRE_LAST);
    else                  stb.drive = tick && !oddTick && !lastTick;
    if (sampleLate) stb.sample = tick && (oddTick != leadChange) && (tickIdx != '0);
    else            stb.sample = tick && (oddTick == leadChange) && !lastTick;
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/spi_host_dp.sv
module spi_host_dp
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] txByte,
  input  logic              idleHigh,
  input  logic              changeOnTrailing,
  input  logic              selActLow,
  input  logic              rxInvert,
  input  logic              txInvert,
  input  logic              sdi,
  output logic              sck,
  output logic              ss,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] rxByte
);

  logic [DATA_W-1:0] txShift, rxShift, rxNext;
  logic              sckLvl, selOn, sdoBit, sdiBit;

  assign sdiBit = sdi ^ rxInvert;
  assign rxNext = stb.sample ? {rxShift[DATA_W-2:0], sdiBit} : rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      sckLvl  <= 1'b0;
      selOn   <= 1'b0;
      sdoBit  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        selOn   <= 1'b1;
        sckLvl  <= 1'b0;
        rxShift <= '0;
        if (changeOnTrailing) begin
          sdoBit  <= txByte[DATA_W-1];
          txShift <= txByte << 1;
        end else begin
          sdoBit  <= 1'b0;
          txShift <= txByte;
        end
      end else begin
        if (stb.toggle) sckLvl <= ~sckLvl;
        if (stb.drive) begin
          sdoBit  <= txShift[DATA_W-1];
          txShift <= txShift << 1;
        end
        rxShift <= rxNext;
        if (stb.finish) begin
          selOn  <= 1'b0;
          sckLvl <= 1'b0;
          sdoBit <= 1'b0;
          rxByte <= rxNext;
        end
      end
    end
  end

  assign sck = sckLvl ^ idleHigh;
  assign ss  = selOn ^ selActLow;
  assign sdo = sdoBit ^ txInvert;

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgIn,
  input  logic              divWe,
  input  logic [DIV_W-1:0]  divIn,
  input  logic              start,
  input  logic [DATA_W-1:0] txByte,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxByte,
  output logic              sck,
  output logic              ss,
  output logic              sdo,
  input  logic              sdi
);

  cfg_t             cfgAct;
  logic [DIV_W-1:0] divAct;
  strobe_t          stb;

  spi_host_regs #(.DIV_W(DIV_W)) uRegs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .divWe(divWe), .divIn(divIn), .load(stb.load), .busy(busy),
    .cfgAct(cfgAct), .divAct(divAct)
  );

  spi_host_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .divAct(divAct),
    .changeOnTrailing(cfgAct.changeOnTrailing),
    .sampleLate(cfgAct.sampleLate), .quickStart(cfgAct.quickStart),
    .busy(busy), .stb(stb)
  );

  spi_host_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .txByte(txByte),
    .idleHigh(cfgAct.idleHigh), .changeOnTrailing(cfgAct.changeOnTrailing),
    .selActLow(cfgAct.selActLow), .rxInvert(cfgAct.rxInvert),
    .txInvert(cfgAct.txInvert), .sdi(sdi),
    .sck(sck), .ss(ss), .sdo(sdo), .done(done), .rxByte(rxByte)
  );

endmodule

// File: rtl/spi_host_checker.sv
module spi_host_checker
  import spi_host_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic sck,
  input logic ss,
  input logic sdo,
  input cfg_t cfgAct
);

  // R2: idle clock level follows the polarity bit
  a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sck == cfgAct.idleHigh));

  // R2: idle select is inactive
  a_r2_ss_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ss == cfgAct.selActLow));

  // R2: idle data out is the inactive level after polarity
  a_r2_sdo_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sdo == cfgAct.txInvert));

  // R11: select active for the whole transfer
  a_r11_ss_active: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (ss == !cfgAct.selActLow));

  // R3: done marks the end of a running transfer
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R3: done lasts a single cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: settings in use are frozen while busy
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cfgAct));

endmodule

bind spi_host_engine spi_host_checker uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .sck(sck), .ss(ss), .sdo(sdo), .cfgAct(cfgAct)
);

// File: tb/tb_spi_host_engine.sv
`timescale 1ns/1ps
module tb_spi_host_engine;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0, divWe = 1'b0, start = 1'b0;
  logic [6:0] cfgIn = '0;
  logic [7:0] divIn = '0, txByte = '0;
  logic       busy, done, sck, ss, sdo;
  logic [7:0] rxByte;
  logic       sdi = 1'b0;

  int nTests = 0, nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  spi_host_engine dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn), .divWe(divWe),
    .divIn(divIn), .start(start), .txByte(txByte), .busy(busy), .done(done),
    .rxByte(rxByte), .sck(sck), .ss(ss), .sdo(sdo), .sdi(sdi)
  );

  // Peripheral model state for the current frame
  logic       sIdle, sSelAct, sLate, sLeadChg, sRxInv;
  logic [7:0] sTx, sRx;
  int         sK;
  int         edgeCnt;
  time        tSs, tFirst, tSecond;

  function automatic logic lineOf(input logic b, input logic inv);
    return (inv ? ~b : b) ^ sRxInv;
  endfunction

  always @(ss) begin
    if (ss === sSelAct) begin
      tSs = $time;
      sK  = 0;
      sRx = '0;
      if (!sLeadChg) begin
        #1 sdi = lineOf(sTx[7], sLate);
      end
    end
  end

  always @(sck) begin
    if (ss === sSelAct) begin
      edgeCnt++;
      if (edgeCnt == 1) tFirst = $time;
      if (edgeCnt == 2) tSecond = $time;
      if ((sck !== sIdle) == sLeadChg) begin
        // edge that moves data
        if (sLeadChg) begin
          #1 sdi = lineOf(sTx[7-sK], sLate);
        end else if (sK < 7) begin
          sK++;
          #1 sdi = lineOf(sTx[7-sK], sLate);
        end
      end else begin
        // mid-bit edge: record sdo, then flip the sdi presentation
        sRx = {sRx[6:0], sdo};
        #1 sdi = lineOf(sTx[7-sK], !sLate);
        if (sLeadChg) sK++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeRegs(input logic [6:0] cfg, input logic [7:0] div);
    @(negedge clk);
    cfgWe = 1'b1; cfgIn = cfg; divWe = 1'b1; divIn = div;
    @(negedge clk);
    cfgWe = 1'b0; divWe = 1'b0;
  endtask

  // One scenario: program, run a frame, check timing, data and idle levels.
  task automatic runXfer(input logic [6:0] cfg, input logic [7:0] div,
                         input logic [7:0] tx, input logic [7:0] stx,
                         input bit midWr, input logic [6:0] newCfg);
    logic [6:0] idleCfg;
    int lead;
    writeRegs(cfg, div);
    sIdle = cfg[0]; sLeadChg = !cfg[1]; sLate = cfg[2];
    sSelAct = !cfg[4]; sRxInv = cfg[5]; sTx = stx;
    edgeCnt = 0;
    @(negedge clk);
    txByte = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R3 busy after start", int'(busy), 1);
    if (midWr) begin
      repeat (6) @(negedge clk);
      cfgWe = 1'b1; cfgIn = newCfg; divWe = 1'b1; divIn = div + 8'd3;
      @(negedge clk);
      cfgWe = 1'b0; divWe = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    check(busy === 1'b0, "R3 busy low at done", int'(busy), 0);
    check(rxByte === stx, "R3/R5/R9 rx byte", int'(rxByte), int'(stx));
    check(sRx === (tx ^ {8{cfg[6]}}), "R3/R4/R9 sdo line bits", int'(sRx),
          int'(tx ^ {8{cfg[6]}}));
    check(edgeCnt == 16, "R3/R11 sck edges in frame", edgeCnt, 16);
    lead = int'((tFirst - tSs) / 20);
    check(lead == (cfg[3] ? 1 : int'(div) + 1), cfg[3] ? "R7 fast lead" : "R6 lead",
          lead, cfg[3] ? 1 : int'(div) + 1);
    check(int'((tSecond - tFirst) / 20) == int'(div) + 1, "R8 half period",
          int'((tSecond - tFirst) / 20), int'(div) + 1);
    @(negedge clk);
    check(done === 1'b0, "R3 done one cycle", int'(done), 0);
    idleCfg = midWr ? newCfg : cfg;
    check(sck === idleCfg[0], "R2 idle sck", int'(sck), int'(idleCfg[0]));
    check(ss === idleCfg[4], "R2 idle ss", int'(ss), int'(idleCfg[4]));
    check(sdo === idleCfg[6], midWr ? "R10 new sdo idle" : "R2 idle sdo",
          int'(sdo), int'(idleCfg[6]));
  endtask

  initial begin
    sIdle = 0; sSelAct = 0; sLate = 0; sLeadChg = 1; sRxInv = 0; sTx = 0; sRx = 0; sK = 0;
    edgeCnt = 0; tSs = 0; tFirst = 0; tSecond = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(done === 1'b0, "R1 done", int'(done), 0);
    check(sck === 1'b0, "R1 sck", int'(sck), 0);
    check(ss === 1'b1, "R1 ss", int'(ss), 1);
    check(sdo === 1'b0, "R1 sdo", int'(sdo), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ss === 1'b1, "R1 ss after release", int'(ss), 1);

    runXfer(7'h10, 8'd2, 8'hA5, 8'h3C, 1'b0, 7'h00); // R4 leading change, R5 mid
    runXfer(7'h13, 8'd0, 8'h81, 8'h7E, 1'b0, 7'h00); // R4 trailing, idle high
    runXfer(7'h14, 8'd1, 8'h5A, 8'hC3, 1'b0, 7'h00); // R5 late, leading change
    runXfer(7'h16, 8'd3, 8'h0F, 8'hE1, 1'b0, 7'h00); // R5 late, trailing change
    runXfer(7'h1A, 8'd4, 8'h96, 8'h69, 1'b0, 7'h00); // R7 fast start
    runXfer(7'h60, 8'd1, 8'h33, 8'hB4, 1'b0, 7'h00); // R9 inversions, ss active high
    runXfer(7'h10, 8'd2, 8'hC6, 8'h2D, 1'b1, 7'h76); // R10 rewrite while busy
    runXfer(7'h76, 8'd0, 8'h4B, 8'hD2, 1'b0, 7'h00); // R10 new settings used

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule